// File: doc/BRIEF.md
# Indexed Palette Colour Lookup with Sequenced Loading

This block keeps a colour lookup table of 256 entries. Each entry has its own 8-bit red, green and blue component. Software loads the table through a two-register window. Writing the index register selects the entry to load. Colour bytes written to the colormap data register are then stored one component at a time: red first, then green, then blue. After each complete triple the index moves on to the next entry by itself. One bus write may carry a single byte, which is one component. It may also carry a full 32-bit word, which is four components taken from the top byte down. A word write can therefore finish one entry and start the next.

A second, independent port serves scanout. An 8-bit pixel code is presented and, one clock later, the 24-bit RGB colour stored for that code appears. The block keeps a refresh-request flag that tells the display side the palette has changed. Any colormap write sets it, and the display side clears it with a strobe after it has redrawn. Video timing and the framebuffer are outside this block.

Top module: `palette_dac`

## Requirements
- R1: A write to offset 0x00 loads bits 7:0 of the write data as the current palette index and puts the component sequencer back to red.
- R2: A byte write (busWord low) to offset 0x04 stores write-data bits 7:0 as exactly one component of the current entry. Successive components go to red, then green, then blue.
- R3: Storing a blue component advances the index by one modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R4: A word write (busWord high) to offset 0x04 supplies four components in the order bits 31:24, 23:16, 15:8, 7:0. Each one advances the sequencer as a byte write would.
- R5: The bus read data is zero in every cycle, whatever the offset.
- R6: refreshReq is high in the cycle after any colormap write. A refreshDone pulse with no colormap write in the same cycle clears it the next cycle. When both happen in the same cycle, the set wins.
- R7: While reset is asserted, all 768 palette bytes clear to zero, the index clears to 0, the sequencer returns to red, refreshReq is set and pixRgb is zero.
- R8: pixRgb equals {red[p], green[p], blue[p]} (red in bits 23:16, blue in bits 7:0) for the pixCode p sampled one clock earlier. A write to entry p in that same cycle returns the old value.
- R9: Writes to any offset other than 0x00 and 0x04 change neither the palette, the index, the sequencer nor refreshReq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte offset within the register window |
| busWrData | input | 32 | Write data |
| busWord | input | 1 | High: 32-bit access; low: byte access in bits 7:0 |
| busRdData | output | 32 | Register read data (always zero) |
| refreshDone | input | 1 | Display side finished a full redraw |
| refreshReq | output | 1 | Palette changed since the last redraw |
| pixCode | input | 8 | Pixel code to look up |
| pixRgb | output | 24 | Colour for the pixel code of the previous cycle |

## Verification
A write takes effect on the clock edge that samples it. Both the sequencer state and refreshReq can be seen one cycle after the write strobe. A lookup result is due exactly one edge after its pixel code is driven. The bench keeps a cycle counter and tags each expected colour with the cycle it is due in. A monitor at the falling edge takes out only the entries due in that cycle. Because of this, a lookup issued in the same cycle as a write to the same entry is compared against the colour from before the write. Flag and read-data checks are sampled on the falling edge right after the edge that commits the write.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int COMP_W = 8;
  localparam int IDX_W  = 8;
  localparam int LANES  = 4;
  localparam int NCHAN  = 3;
  localparam int BUS_W  = COMP_W * LANES;
  localparam int RGB_W  = COMP_W * NCHAN;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;

  // one component store request per byte lane of a bus write
  typedef struct packed {
    logic              en;
    phase_e            chan;
    logic [IDX_W-1:0]  idx;
    logic [COMP_W-1:0] val;
  } laneStrobe_t;

  typedef struct packed {
    laneStrobe_t [LANES-1:0] lane;
  } palWrite_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWord,
  input  logic              refreshDone,
  output palWrite_t         wrStrobe,
  output logic              refreshReq,
  output logic [IDX_W-1:0]  curIndex,
  output phase_e            curPhase
);
  logic             idxHit, mapHit;
  phase_e           walkPh;
  logic [IDX_W-1:0] walkIdx;

  assign idxHit = busWrEn && (busAddr == ADDR_W'(IDX_OFS));
  assign mapHit = busWrEn && (busAddr == ADDR_W'(MAP_OFS));

  // walk the sequencer across the active lanes, top byte first
  always_comb begin
    walkPh   = curPhase;
    walkIdx  = curIndex;
    wrStrobe = '0;
    for (int k = 0; k < LANES; k++) begin
      if (mapHit && (busWord || k == 0)) begin
        wrStrobe.lane[k].en   = 1'b1;
        wrStrobe.lane[k].chan = walkPh;
        wrStrobe.lane[k].idx  = walkIdx;
        wrStrobe.lane[k].val  = busWord ? busWrData[BUS_W-1-k*COMP_W -: COMP_W]
                                        : busWrData[COMP_W-1:0];
        if (walkPh == PH_BLU) begin
          walkPh  = PH_RED;
          walkIdx = walkIdx + IDX_W'(1);
        end else begin
          walkPh = phase_e'(walkPh + 2'd1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex   <= '0;
      curPhase   <= PH_RED;
      refreshReq <= 1'b1;
    end else begin
      if (idxHit) begin
        curIndex <= busWrData[IDX_W-1:0];
        curPhase <= PH_RED;
      end else if (mapHit) begin
        curIndex <= walkIdx;
        curPhase <= walkPh;
      end
      if (mapHit)           refreshReq <= 1'b1;
      else if (refreshDone) refreshReq <= 1'b0;
    end
  end
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  palWrite_t        wrStrobe,
  input  logic [IDX_W-1:0] pixCode,
  output logic [RGB_W-1:0] pixRgb
);
  logic [COMP_W-1:0] chanOut [NCHAN];

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    logic [COMP_W-1:0] tab [ENTRIES];
    logic [COMP_W-1:0] rdq;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int e = 0; e < ENTRIES; e++) tab[e] <= '0;
        rdq <= '0;
      end else begin
        for (int k = 0; k < LANES; k++) begin
          if (wrStrobe.lane[k].en && (int'(wrStrobe.lane[k].chan) == ch))
            tab[wrStrobe.lane[k].idx] <= wrStrobe.lane[k].val;
        end
        rdq <= tab[pixCode];
      end
    end

    assign chanOut[ch] = rdq;
  end

  assign pixRgb = {chanOut[0], chanOut[1], chanOut[2]};
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import palette_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWord,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              refreshDone,
  output logic              refreshReq,
  input  logic [IDX_W-1:0]  pixCode,
  output logic [RGB_W-1:0]  pixRgb
);
  palWrite_t        wrStrobe;
  logic [IDX_W-1:0] curIndex;
  phase_e           curPhase;

  assign busRdData = '0;

  palette_ctrl #(.ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busWord(busWord), .refreshDone(refreshDone),
    .wrStrobe(wrStrobe), .refreshReq(refreshReq),
    .curIndex(curIndex), .curPhase(curPhase)
  );

  palette_store #(.ENTRIES(1 << IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe),
    .pixCode(pixCode), .pixRgb(pixRgb)
  );
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk
  import palette_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_OFS = 0,
  parameter int MAP_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [IDX_W-1:0]  idxData,
  input logic              busWord,
  input logic              refreshDone,
  input logic              refreshReq,
  input logic [IDX_W-1:0]  curIndex,
  input phase_e            curPhase
);
  logic mapWr, idxWr;
  assign mapWr = busWrEn && (busAddr == ADDR_W'(MAP_OFS));
  assign idxWr = busWrEn && (busAddr == ADDR_W'(IDX_OFS));

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (curPhase == PH_RED) && (curIndex == $past(idxData)));

  // R2
  byte_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mapWr && !busWord && curPhase == PH_RED) |=>
      (curPhase == PH_GRN) && (curIndex == $past(curIndex)));

  // R3
  blue_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mapWr && !busWord && curPhase == PH_BLU) |=>
      (curPhase == PH_RED) && (curIndex == IDX_W'($past(curIndex) + 1)));

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mapWr && busWord && curPhase == PH_RED) |=>
      (curPhase == PH_GRN) && (curIndex == IDX_W'($past(curIndex) + 1)));

  // R6
  refresh_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapWr |=> refreshReq);

  // R6
  refresh_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refreshDone && !mapWr) |=> !refreshReq);

  // R9
  other_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mapWr && !idxWr) |=> ($stable(curIndex) && $stable(curPhase)));
endmodule

bind palette_dac palette_dac_chk #(.ADDR_W(ADDR_W), .IDX_OFS(IDX_OFS), .MAP_OFS(MAP_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .idxData(busWrData[7:0]), .busWord(busWord), .refreshDone(refreshDone),
  .refreshReq(refreshReq), .curIndex(curIndex), .curPhase(curPhase)
);

// File: tb/palette_dac_tb.sv
module palette_dac_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWord = 1'b0;
  logic [31:0] busRdData;
  logic        refreshDone = 1'b0;
  logic        refreshReq;
  logic [7:0]  pixCode = '0;
  logic [23:0] pixRgb;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit done    = 0;

  // model state
  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] mIdx;
  int         mPh;

  typedef struct {
    int          due;
    logic [23:0] exp;
    logic [7:0]  code;
    string       req;
  } item_t;
  item_t q[$];

  palette_dac u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busWord(busWord), .busRdData(busRdData),
    .refreshDone(refreshDone), .refreshReq(refreshReq),
    .pixCode(pixCode), .pixRgb(pixRgb)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare lookups in the cycle they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      chk(pixRgb == it.exp, it.req, {8'h0, pixRgb}, {8'h0, it.exp});
    end
  end

  // driver: present a pixel code, queue the expected colour
  task automatic look(input logic [7:0] code, input string req);
    item_t it;
    pixCode = code;
    it.due  = cyc + 1;
    it.exp  = {mr[code], mg[code], mb[code]};
    it.code = code;
    it.req  = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrIdx(input logic [7:0] v);
    busWrEn = 1; busAddr = 5'h00; busWrData = {24'h0, v}; busWord = 0;
    mIdx = v; mPh = 0;
    step();
    busWrEn = 0;
  endtask

  task automatic modelComp(input logic [7:0] b);
    case (mPh)
      0: mr[mIdx] = b;
      1: mg[mIdx] = b;
      default: mb[mIdx] = b;
    endcase
    if (mPh == 2) begin mPh = 0; mIdx = mIdx + 8'd1; end
    else mPh = mPh + 1;
  endtask

  task automatic wrMap(input logic [31:0] d, input bit word);
    busWrEn = 1; busAddr = 5'h04; busWrData = d; busWord = word;
    if (word) for (int k = 0; k < 4; k++) modelComp(d[31-8*k -: 8]);
    else modelComp(d[7:0]);
    step();
    busWrEn = 0; busWord = 0;
  endtask

  task automatic wrOther(input logic [4:0] a, input logic [31:0] d, input bit word);
    busWrEn = 1; busAddr = a; busWrData = d; busWord = word;
    step();
    busWrEn = 0; busWord = 0;
  endtask

  initial begin
    for (int e = 0; e < 256; e++) begin mr[e] = 0; mg[e] = 0; mb[e] = 0; end
    mIdx = 0; mPh = 0;
    repeat (3) step();
    // R7: state while in reset
    chk(refreshReq == 1'b1, "R7 refreshReq in reset", {31'h0, refreshReq}, 32'h1);
    chk(pixRgb == 24'h0, "R7 pixRgb in reset", {8'h0, pixRgb}, 32'h0);
    rstN = 1;
    // R7: palette cleared
    look(8'h00, "R7 entry 0 cleared"); step();
    look(8'hFF, "R7 entry 255 cleared"); step();
    chk(busRdData == 32'h0, "R5 read data zero", busRdData, 32'h0);

    // R6 clear by refreshDone
    refreshDone = 1; step(); refreshDone = 0;
    chk(refreshReq == 1'b0, "R6 cleared by refreshDone", {31'h0, refreshReq}, 32'h0);

    // R2: byte loads red, green, blue; R3: index advance
    wrIdx(8'd5);
    wrMap(32'h11, 0);
    chk(refreshReq == 1'b1, "R6 set by colormap write", {31'h0, refreshReq}, 32'h1);
    wrMap(32'hFFFF_FF22, 0);
    wrMap(32'h33, 0);
    chk(busRdData == 32'h0, "R5 read data zero after writes", busRdData, 32'h0);
    wrMap(32'h44, 0);                   // red of entry 6
    look(8'd5, "R2 entry 5 triple"); step();
    look(8'd6, "R3 auto-increment to entry 6"); step();

    // R1: index write mid-triple restarts at red
    wrMap(32'h55, 0);                   // green of entry 6
    wrIdx(8'd9);
    wrMap(32'hAA, 0);                   // red of entry 9
    look(8'd9, "R1 index reload resets phase"); step();
    look(8'd6, "R1 partial entry 6"); step();

    // R4 word writes, R3 wrap at 255
    wrIdx(8'd254);
    wrMap(32'h0102_0304, 1);
    wrMap(32'h0506_0708, 1);
    look(8'd254, "R4 word MSB first entry 254"); step();
    look(8'd255, "R4 word spanning entry 255"); step();
    look(8'd0,   "R3 index wraps to 0"); step();

    // R9: other offsets ignored
    refreshDone = 1; step(); refreshDone = 0;
    wrOther(5'h10, 32'hFFFF_FFFF, 1);
    wrOther(5'h08, 32'h77, 0);
    wrOther(5'h05, 32'h66, 0);
    step();
    chk(refreshReq == 1'b0, "R9 refreshReq untouched", {31'h0, refreshReq}, 32'h0);
    wrMap(32'h09, 0);                   // blue of entry 0
    look(8'd0, "R9 sequencer and index unchanged"); step();
    look(8'd1, "R9 entry 1 untouched"); step();

    // R8 same-cycle write and lookup of one entry
    wrIdx(8'd0);
    look(8'd0, "R8 old value on same-cycle write");
    wrMap(32'hEE, 0);
    look(8'd0, "R8 new value next cycle"); step();

    // R6 set wins over refreshDone
    refreshDone = 1;
    wrMap(32'h12, 0);
    refreshDone = 0;
    chk(refreshReq == 1'b1, "R6 set wins over clear", {31'h0, refreshReq}, 32'h1);

    // R8 back-to-back lookups of distinct codes
    look(8'd254, "R8 stream 254"); step();
    look(8'd9,   "R8 stream 9");   step();
    look(8'd255, "R8 stream 255"); step();
    repeat (3) step();
    chk(q.size() == 0, "R8 all lookups returned", q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule